// File: doc/BRIEF.md
# LCD Panel Timing Controller

This block produces the line sync, frame sync, data-enable and start-of-frame signals for a parallel RGB panel. It also gates the pixel data going to that panel. Software programs the porch, pulse and active-area sizes through a small word-addressed register port. It then starts the controller in three stages: pixel clock, then sync generation, then display data. It polls a status word between steps and shuts the stages down in the reverse order.

All logic runs on the system clock. The pixel rate is a clock enable, `pix_ce`, which pulses once per pixel. It is derived from the system clock (the fast source) or from half of it (the slow source), divided by a programmable divisor. A stage's status bit follows its request only at a boundary. For the pixel-clock stage that boundary is the end of a divider period. For the sync and display stages it is the end of a frame, or any pixel tick while sync is stopped. The sync stage can only start while the pixel-clock stage is running. The display stage can only start while the sync stage is running. A sticky start-of-frame flag, masked by an enable bit, drives the interrupt line.

Register map (word index on `reg_addr`): 0 = sync widths, 1 = vertical porches, 2 = horizontal porches, 3 = active area, 4 = clock config, 5 = output config, 6 = stage on, 7 = stage off, 8 = stage status, 9 = irq enable, 10 = irq disable, 11 = irq mask read, 12 = irq flag read.

Top module: `lcd_timing_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every stage is stopped, all config words and the irq mask and flag read 0, hsync/vsync/de/irq are low and rgb is 0.
- R2: Writing ones to word 6 sets stage requests and writing ones to word 7 clears them (bit0 pixel clock, bit1 sync, bit2 display). Word 8 returns the running stages in the same bit order. A status bit changes only at its stage boundary.
- R3: The sync stage does not start unless the pixel-clock stage is running at that boundary. The display stage does not start unless the sync stage is running at that boundary.
- R4: `pix_ce` pulses only while the pixel-clock stage runs. Its period is D system cycles with word 4 bit0 = 1, or 2·D cycles with bit0 = 0. D is word 4 bits [15:8], with values below 2 treated as 2.
- R5: Word 0 holds hsync width−1 (low half) and vsync width−1 (high half). Word 1 holds vertical front porch−1 (low) and vertical back porch with no offset (high). Word 2 holds horizontal front porch−1 (low) and back porch−1 (high). Word 3 holds active width−1 (low) and height−1 (high). Each line and frame runs in the order sync pulse, back porch, active, front porch.
- R6: Word 5 bit0 inverts hsync and bit1 inverts vsync. While the sync stage is stopped, both outputs sit at their inactive level.
- R7: `de` is high only inside the active area while both the sync and display stages run. `rgb` is 0 whenever `de` is low.
- R8: Word 5 bits [9:8] select the output depth: 0 gives 4/4/4, 1 gives 5/6/5, 2 gives 6/6/6 and 3 gives 8/8/8 bits of R/G/B. The kept bits are the top bits of each 8-bit lane of `pix_in` (R = [23:16], G = [15:8], B = [7:0]), and the rest are driven to 0.
- R9: The start-of-frame flag (word 12 bit0) is set on the first pixel of each frame, which lies in the first vsync line. It stays set until word 12 is read, and a set in the same cycle as that read wins.
- R10: `irq` equals the flag ANDed with the mask. Writing bit0 = 1 to word 9 sets the mask, writing bit0 = 1 to word 10 clears it, and word 11 reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears the flag when it reads word 12) |
| reg_addr | input | 4 | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from reg_addr) |
| pix_in | input | 24 | Pixel colour in, R/G/B lanes of 8 bits |
| pix_ce | output | 1 | One-cycle pulse at the end of each pixel |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| rgb | output | 24 | Gated and depth-masked pixel data |
| irq | output | 1 | Start-of-frame interrupt |

## Verification
The hardest situation to reach from the ports is a stage request that arrives while its predecessor is not running. Equally hard is a request that arrives mid-frame, so that it must wait for a boundary. The stimulus requests sync and display with the pixel clock off and holds them across many divider periods. It then brings the stages up one at a time, reading the status word in the cycle right after each write. A behavioural reference model runs alongside and is compared on every clock. The stimulus also changes the divider, the source, the polarity, the depth and the vertical back porch while frames are running, so boundaries land mid-line.

// File: rtl/lcd_tc_pkg.sv
// Shared constants and types for the LCD timing controller.
// Assumes a 4-bit word-addressed register port with 32-bit data.
package lcd_tc_pkg;
    localparam int FIELD_W = 16;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int PIX_W   = 24;

    typedef enum logic [ADDR_W-1:0] {
        A_SYNCW    = 4'd0,
        A_VPORCH   = 4'd1,
        A_HPORCH   = 4'd2,
        A_ACTIVE   = 4'd3,
        A_CLKCFG   = 4'd4,
        A_OUTCFG   = 4'd5,
        A_STG_ON   = 4'd6,
        A_STG_OFF  = 4'd7,
        A_STG_STAT = 4'd8,
        A_IRQ_ON   = 4'd9,
        A_IRQ_OFF  = 4'd10,
        A_IRQ_MASK = 4'd11,
        A_IRQ_FLAG = 4'd12
    } reg_addr_e;

    localparam int ST_PCLK = 0;
    localparam int ST_SYNC = 1;
    localparam int ST_DISP = 2;

    typedef struct packed {
        logic [FIELD_W-1:0] vsw_m1;
        logic [FIELD_W-1:0] hsw_m1;
        logic [FIELD_W-1:0] vbp;
        logic [FIELD_W-1:0] vfp_m1;
        logic [FIELD_W-1:0] hbp_m1;
        logic [FIELD_W-1:0] hfp_m1;
        logic [FIELD_W-1:0] vact_m1;
        logic [FIELD_W-1:0] hact_m1;
    } timing_cfg_t;
endpackage

// File: rtl/lcd_tc_regs.sv
// Register file: timing words, clock/output config, stage requests
// (set/clear pair), irq mask (set/clear pair) and the sticky frame flag.
// Assumes single-cycle write and read strobes; reads are combinational.
module lcd_tc_regs
    import lcd_tc_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic                 re,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic [2:0]           stage_stat,
    input  logic                 sof_set,
    output timing_cfg_t          cfg,
    output logic [DIV_W-1:0]     div_val,
    output logic                 src_fast,
    output logic                 hs_inv,
    output logic                 vs_inv,
    output logic [1:0]           out_mode,
    output logic [2:0]           stage_req,
    output logic                 irq_mask,
    output logic                 sof_flag
);
    localparam int DIV_LSB = 8;

    // Configuration words, requests and mask, written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg       <= '0;
            div_val   <= '0;
            src_fast  <= 1'b0;
            hs_inv    <= 1'b0;
            vs_inv    <= 1'b0;
            out_mode  <= 2'd0;
            stage_req <= 3'b000;
            irq_mask  <= 1'b0;
        end else if (we) begin
            case (addr)
                A_SYNCW:   {cfg.vsw_m1, cfg.hsw_m1}   <= wdata;
                A_VPORCH:  {cfg.vbp, cfg.vfp_m1}      <= wdata;
                A_HPORCH:  {cfg.hbp_m1, cfg.hfp_m1}   <= wdata;
                A_ACTIVE:  {cfg.vact_m1, cfg.hact_m1} <= wdata;
                A_CLKCFG: begin
                    src_fast <= wdata[0];
                    div_val  <= wdata[DIV_LSB +: DIV_W];
                end
                A_OUTCFG: begin
                    hs_inv   <= wdata[0];
                    vs_inv   <= wdata[1];
                    out_mode <= wdata[9:8];
                end
                A_STG_ON:  stage_req <= stage_req | wdata[2:0];
                A_STG_OFF: stage_req <= stage_req & ~wdata[2:0];
                A_IRQ_ON:  if (wdata[0]) irq_mask <= 1'b1;
                A_IRQ_OFF: if (wdata[0]) irq_mask <= 1'b0;
                default: ;
            endcase
        end
    end

    // Sticky start-of-frame flag; a new frame wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sof_flag <= 1'b0;
        else if (sof_set)
            sof_flag <= 1'b1;
        else if (re && addr == A_IRQ_FLAG)
            sof_flag <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_SYNCW:    rdata = {cfg.vsw_m1, cfg.hsw_m1};
            A_VPORCH:   rdata = {cfg.vbp, cfg.vfp_m1};
            A_HPORCH:   rdata = {cfg.hbp_m1, cfg.hfp_m1};
            A_ACTIVE:   rdata = {cfg.vact_m1, cfg.hact_m1};
            A_CLKCFG:   begin
                rdata[0] = src_fast;
                rdata[DIV_LSB +: DIV_W] = div_val;
            end
            A_OUTCFG:   rdata = {22'd0, out_mode, 6'd0, vs_inv, hs_inv};
            A_STG_STAT: rdata = {29'd0, stage_stat};
            A_IRQ_MASK: rdata = {31'd0, irq_mask};
            A_IRQ_FLAG: rdata = {31'd0, sof_flag};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/lcd_tc_clkdiv.sv
// Pixel-rate divider and pixel-clock stage. Produces a wrap pulse every
// period (D or 2*D system cycles, D clamped to at least 2); the stage's
// running bit follows its request only at a wrap.
module lcd_tc_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             src_fast,
    input  logic             pclk_req,
    output logic             wrap,
    output logic             pclk_on
);
    localparam int CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] eff_div;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt;

    // Effective period from divisor and source select.
    always_comb begin
        eff_div = (div_val < DIV_W'(2)) ? DIV_W'(2) : div_val;
        period  = src_fast ? {1'b0, eff_div} : {eff_div, 1'b0};
        wrap    = (cnt >= period - CNT_W'(1));
    end

    // Free-running period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (wrap)    cnt <= '0;
        else              cnt <= cnt + CNT_W'(1);
    end

    // Pixel-clock stage status, updated only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    pclk_on <= 1'b0;
        else if (wrap) pclk_on <= pclk_req;
    end
endmodule

// File: rtl/lcd_tc_stages.sv
// Sync and display stage status. Each follows its request at a frame
// edge, and may only start while the preceding stage is running.
module lcd_tc_stages (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    input  logic disp_req,
    input  logic pclk_on,
    input  logic frame_edge,
    output logic sync_on,
    output logic disp_on
);
    // Boundary-aligned, predecessor-gated stage updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_on <= 1'b0;
            disp_on <= 1'b0;
        end else if (frame_edge) begin
            sync_on <= sync_req & pclk_on;
            disp_on <= disp_req & sync_on;
        end
    end
endmodule

// File: rtl/lcd_tc_timing.sv
// Line/frame counters and panel outputs. Each line and frame runs sync,
// back porch, active, front porch. Counters hold at zero while sync stops.
// Assumes config changes are tolerated mid-frame (counters clamp at >=).
module lcd_tc_timing
    import lcd_tc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  timing_cfg_t       cfg,
    input  logic              pix_tick,
    input  logic              sync_on,
    input  logic              disp_on,
    input  logic              hs_inv,
    input  logic              vs_inv,
    input  logic [1:0]        out_mode,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              frame_edge,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [PIX_W-1:0]  rgb
);
    localparam int CNT_W = FIELD_W + 3;
    localparam int NCH   = 3;
    localparam int LANE  = PIX_W / NCH;

    logic [CNT_W-1:0] hcnt, vcnt;
    logic [CNT_W-1:0] h_bp_end, h_act_end, h_tot, v_bp_end, v_act_end, v_tot;
    logic [CNT_W-1:0] hsw, vsw;
    logic             h_last, v_last, in_act;

    // Region boundaries from the stored (mostly minus-one) fields.
    always_comb begin
        hsw       = CNT_W'(cfg.hsw_m1) + CNT_W'(1);
        vsw       = CNT_W'(cfg.vsw_m1) + CNT_W'(1);
        h_bp_end  = hsw + CNT_W'(cfg.hbp_m1) + CNT_W'(1);
        h_act_end = h_bp_end + CNT_W'(cfg.hact_m1) + CNT_W'(1);
        h_tot     = h_act_end + CNT_W'(cfg.hfp_m1) + CNT_W'(1);
        v_bp_end  = vsw + CNT_W'(cfg.vbp);
        v_act_end = v_bp_end + CNT_W'(cfg.vact_m1) + CNT_W'(1);
        v_tot     = v_act_end + CNT_W'(cfg.vfp_m1) + CNT_W'(1);
        h_last    = (hcnt >= h_tot - CNT_W'(1));
        v_last    = (vcnt >= v_tot - CNT_W'(1));
        frame_edge = pix_tick & (~sync_on | (h_last & v_last));
    end

    // Position counters advance once per pixel tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (pix_tick) begin
            if (frame_edge) begin
                hcnt <= '0;
                vcnt <= '0;
            end else if (h_last) begin
                hcnt <= '0;
                vcnt <= vcnt + CNT_W'(1);
            end else begin
                hcnt <= hcnt + CNT_W'(1);
            end
        end
    end

    // Sync pulses and data enable.
    always_comb begin
        hsync  = (sync_on & (hcnt < hsw)) ^ hs_inv;
        vsync  = (sync_on & (vcnt < vsw)) ^ vs_inv;
        in_act = (hcnt >= h_bp_end) & (hcnt < h_act_end) &
                 (vcnt >= v_bp_end) & (vcnt < v_act_end);
        de     = disp_on & sync_on & in_act;
    end

    // Kept bits per lane (lane 0 = blue, 1 = green, 2 = red).
    function automatic int lane_bits(input int lane, input logic [1:0] mode);
        case (mode)
            2'd0:    return 4;
            2'd1:    return (lane == 1) ? 6 : 5;
            2'd2:    return 6;
            default: return 8;
        endcase
    endfunction

    // Per-lane depth masking and gating.
    for (genvar g = 0; g < NCH; g++) begin : g_lane
        logic [LANE-1:0] keep;
        always_comb begin
            keep = {LANE{1'b1}} << (LANE - lane_bits(g, out_mode));
            rgb[g*LANE +: LANE] = de ? (pix_in[g*LANE +: LANE] & keep) : '0;
        end
    end
endmodule

// File: rtl/lcd_timing_ctrl.sv
// Top level of the LCD panel timing controller: register file, pixel
// divider, staged enables and timing generator. Single system clock; the
// pixel rate is a clock enable (pix_ce).
module lcd_timing_ctrl
    import lcd_tc_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [23:0]       pix_in,
    output logic              pix_ce,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [23:0]       rgb,
    output logic              irq
);
    timing_cfg_t      cfg;
    logic [DIV_W-1:0] div_val;
    logic             src_fast, hs_inv, vs_inv;
    logic [1:0]       out_mode;
    logic [2:0]       stage_req, stage_stat;
    logic             irq_mask, sof_flag, sof_set;
    logic             wrap, pclk_on, sync_on, disp_on, frame_edge;

    lcd_tc_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .re(reg_re),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .stage_stat(stage_stat), .sof_set(sof_set), .cfg(cfg),
        .div_val(div_val), .src_fast(src_fast), .hs_inv(hs_inv),
        .vs_inv(vs_inv), .out_mode(out_mode), .stage_req(stage_req),
        .irq_mask(irq_mask), .sof_flag(sof_flag)
    );

    lcd_tc_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .src_fast(src_fast),
        .pclk_req(stage_req[ST_PCLK]), .wrap(wrap), .pclk_on(pclk_on)
    );

    lcd_tc_stages u_stg (
        .clk(clk), .rst_n(rst_n), .sync_req(stage_req[ST_SYNC]),
        .disp_req(stage_req[ST_DISP]), .pclk_on(pclk_on),
        .frame_edge(frame_edge), .sync_on(sync_on), .disp_on(disp_on)
    );

    lcd_tc_timing u_tim (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .pix_tick(pix_ce),
        .sync_on(sync_on), .disp_on(disp_on), .hs_inv(hs_inv),
        .vs_inv(vs_inv), .out_mode(out_mode), .pix_in(pix_in),
        .frame_edge(frame_edge), .hsync(hsync), .vsync(vsync),
        .de(de), .rgb(rgb)
    );

    // Glue: pixel tick, stage status word, frame-start event, interrupt.
    always_comb begin
        pix_ce     = wrap & pclk_on;
        stage_stat = {disp_on, sync_on, pclk_on};
        sof_set    = frame_edge & stage_req[ST_SYNC] & pclk_on;
        irq        = sof_flag & irq_mask;
    end
endmodule

// File: rtl/lcd_tc_checker.sv
// Assertion checker bound to the top level; observes ports and the
// stage/irq state that separate submodules drive.
module lcd_tc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  stat,
    input logic        pix_ce,
    input logic        de,
    input logic [23:0] rgb,
    input logic        irq,
    input logic        irq_mask,
    input logic        sof_flag,
    input logic        reg_re,
    input logic [3:0]  reg_addr
);
    a_r3_sync_needs_pclk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[1]) |-> $past(stat[0]));
    a_r3_disp_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[2]) |-> $past(stat[1]));
    a_r2_sync_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[1] != $past(stat[1])) |-> $past(pix_ce));
    a_r4_ce_needs_pclk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |-> stat[0]);
    a_r7_de_needs_disp: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (stat[2] && stat[1]));
    a_r7_rgb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (rgb == 24'd0));
    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_mask);
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_flag && !(reg_re && reg_addr == 4'd12)) |=> sof_flag);
endmodule

bind lcd_timing_ctrl lcd_tc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .stat(stage_stat), .pix_ce(pix_ce),
    .de(de), .rgb(rgb), .irq(irq), .irq_mask(irq_mask),
    .sof_flag(sof_flag), .reg_re(reg_re), .reg_addr(reg_addr)
);

// File: tb/lcd_timing_ctrl_tb.sv
// Self-checking bench with a behavioural cycle model compared every clock.
module lcd_timing_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [23:0] pix_in = 24'h5A3CC3;
    logic        pix_ce, hsync, vsync, de, irq;
    logic [23:0] rgb;

    int errors = 0, checks = 0;
    bit cmp_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_timing_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pix_in(pix_in), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync),
        .de(de), .rgb(rgb), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural model ----------------
    int m_cnt, m_h, m_v;
    bit m_pclk, m_sync, m_disp, m_flag, m_mask;
    bit [2:0] m_req;
    bit [31:0] w_syn, w_vp, w_hp, w_act, w_clk, w_out;

    function automatic int lo(bit [31:0] w); return int'(w[15:0]); endfunction
    function automatic int hi(bit [31:0] w); return int'(w[31:16]); endfunction
    function automatic int per();
        int d = int'(w_clk[15:8]);
        if (d < 2) d = 2;
        return w_clk[0] ? d : 2 * d;
    endfunction
    function automatic int hsw();  return lo(w_syn) + 1; endfunction
    function automatic int vsw();  return hi(w_syn) + 1; endfunction
    function automatic int hbe();  return hsw() + hi(w_hp) + 1; endfunction
    function automatic int hae();  return hbe() + lo(w_act) + 1; endfunction
    function automatic int htot(); return hae() + lo(w_hp) + 1; endfunction
    function automatic int vbe();  return vsw() + hi(w_vp); endfunction
    function automatic int vae();  return vbe() + hi(w_act) + 1; endfunction
    function automatic int vtot(); return vae() + lo(w_vp) + 1; endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_h = 0; m_v = 0; m_pclk = 0; m_sync = 0; m_disp = 0;
            m_flag = 0; m_mask = 0; m_req = 0;
            w_syn = 0; w_vp = 0; w_hp = 0; w_act = 0; w_clk = 0; w_out = 0;
        end else begin
            bit wrap, tick, fe, sof, hl, vl, old_sync;
            wrap = (m_cnt >= per() - 1);
            tick = wrap && m_pclk;
            hl = (m_h >= htot() - 1);
            vl = (m_v >= vtot() - 1);
            fe = tick && (!m_sync || (hl && vl));
            sof = fe && m_req[1] && m_pclk;
            old_sync = m_sync;
            if (tick) begin
                if (fe) begin m_h = 0; m_v = 0; end
                else if (hl) begin m_h = 0; m_v++; end
                else m_h++;
            end
            if (fe) begin
                m_sync = m_req[1] && m_pclk;
                m_disp = m_req[2] && old_sync;
            end
            if (wrap) m_pclk = m_req[0];
            m_cnt = wrap ? 0 : m_cnt + 1;
            if (sof) m_flag = 1;
            else if (reg_re && reg_addr == 4'd12) m_flag = 0;
            if (reg_we) begin
                case (reg_addr)
                    4'd0: w_syn = reg_wdata;
                    4'd1: w_vp = reg_wdata;
                    4'd2: w_hp = reg_wdata;
                    4'd3: w_act = reg_wdata;
                    4'd4: w_clk = reg_wdata;
                    4'd5: w_out = reg_wdata;
                    4'd6: m_req = m_req | reg_wdata[2:0];
                    4'd7: m_req = m_req & ~reg_wdata[2:0];
                    4'd9: if (reg_wdata[0]) m_mask = 1;
                    4'd10: if (reg_wdata[0]) m_mask = 0;
                    default: ;
                endcase
            end
        end
    end

    function automatic bit [23:0] exp_rgb(bit e);
        int wr, wg, wb;
        bit [7:0] r, g, b;
        case (w_out[9:8])
            2'd0: begin wr = 4; wg = 4; wb = 4; end
            2'd1: begin wr = 5; wg = 6; wb = 5; end
            2'd2: begin wr = 6; wg = 6; wb = 6; end
            default: begin wr = 8; wg = 8; wb = 8; end
        endcase
        if (!e) return 24'd0;
        r = pix_in[23:16] & (8'hFF << (8 - wr));
        g = pix_in[15:8]  & (8'hFF << (8 - wg));
        b = pix_in[7:0]   & (8'hFF << (8 - wb));
        return {r, g, b};
    endfunction

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            bit e_ce, e_hs, e_vs, e_de;
            e_ce = (m_cnt >= per() - 1) && m_pclk;
            e_hs = (m_sync && m_h < hsw()) ^ w_out[0];
            e_vs = (m_sync && m_v < vsw()) ^ w_out[1];
            e_de = m_disp && m_sync && m_h >= hbe() && m_h < hae() &&
                   m_v >= vbe() && m_v < vae();
            chk(pix_ce == e_ce, "R4 pix_ce", pix_ce, e_ce);
            chk(hsync == e_hs, "R5/R6 hsync", hsync, e_hs);
            chk(vsync == e_vs, "R5/R6 vsync", vsync, e_vs);
            chk(de == e_de, "R7 de", de, e_de);
            chk(rgb == exp_rgb(e_de), "R8 rgb", rgb, exp_rgb(e_de));
            chk(irq == (m_flag && m_mask), "R10 irq", irq, m_flag && m_mask);
        end
        pix_in <= pix_in * 24'd7 + 24'h1357;
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input int a, input bit [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input int a, output bit [31:0] d);
        @(negedge clk);
        reg_re = 1; reg_addr = 4'(a);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 0;
    endtask

    task automatic poll(input int bitn, input bit val, input string tag);
        bit [31:0] d;
        int n = 0;
        do begin rd(8, d); n++; end while (d[bitn] != val && n < 500);
        chk(d[bitn] == val, tag, d[bitn], val);
    endtask

    task automatic run();
        bit [31:0] d;
        int cnt, den;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk({hsync, vsync, de, irq} == 4'b0, "R1 outputs idle", {hsync, vsync, de, irq}, 0);
        chk(rgb == 0, "R1 rgb zero", rgb, 0);
        rd(8, d); chk(d == 0, "R1 status zero", d, 0);
        rd(0, d); chk(d == 0, "R1 sync word zero", d, 0);
        rd(12, d); chk(d == 0, "R1 flag zero", d, 0);
        cmp_on = 1;
        // R5 timing: hsw2 hbp1 hact4 hfp1; vsw1 vbp0 vact3 vfp1
        wr(0, 32'h0000_0001);
        wr(1, 32'h0000_0000);
        wr(2, 32'h0000_0000);
        wr(3, 32'h0002_0003);
        wr(4, 32'h0000_0201);
        wr(5, 32'h0000_0300);
        // R3 gating: sync/display requested without pixel clock
        wr(6, 32'h6);
        repeat (200) @(negedge clk);
        rd(8, d); chk(d == 0, "R3 no start without pclk", d, 0);
        wr(7, 32'h6);
        // R2 ordered bring-up
        wr(6, 32'h1);
        poll(0, 1, "R2 pclk up");
        rd(8, d); chk(d[2:1] == 0, "R2 only pclk running", d, 1);
        wr(6, 32'h4);
        repeat (50) @(negedge clk);
        rd(8, d); chk(d[2] == 0, "R3 display waits for sync", d[2], 0);
        wr(7, 32'h4);
        wr(6, 32'h2);
        poll(1, 1, "R2 sync up");
        wr(6, 32'h4);
        rd(8, d); chk(d == {29'd0, m_disp, m_sync, m_pclk}, "R2 disp at boundary only", d, {m_disp, m_sync, m_pclk});
        poll(2, 1, "R2 display up");
        // R9/R10 interrupt
        wr(9, 32'h1);
        rd(11, d); chk(d == 1, "R10 mask readback", d, 1);
        cnt = 0;
        while (!irq && cnt < 1000) begin @(negedge clk); cnt++; end
        chk(irq == 1, "R10 irq asserted", irq, 1);
        // R5 active count per frame (vbp 0): 4x3
        den = 0;
        for (int i = 0; i < 40; i++) begin
            do @(negedge clk); while (!pix_ce);
            if (de) den++;
        end
        chk(den == 12, "R5 active pixels vbp0", den, 12);
        rd(12, d); chk(d[0] == 1, "R9 flag sticky", d[0], 1);
        rd(12, d); chk(d[0] == m_flag, "R9 cleared on read", d[0], m_flag);
        wr(10, 32'h1);
        repeat (200) @(negedge clk);
        chk(irq == 0, "R10 irq masked", irq, 0);
        rd(12, d); chk(d[0] == 1, "R9 flag set while masked", d[0], 1);
        // R4 divider rates
        cnt = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (pix_ce) cnt++; end
        chk(cnt == 20, "R4 fast div2 rate", cnt, 20);
        wr(4, 32'h0000_0200);
        repeat (8) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (pix_ce) cnt++; end
        chk(cnt == 10, "R4 slow div2 rate", cnt, 10);
        wr(4, 32'h0000_0001);
        repeat (8) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (pix_ce) cnt++; end
        chk(cnt == 20, "R4 div0 clamps to 2", cnt, 20);
        // R5 nonzero vertical back porch (raw value 2)
        wr(1, 32'h0002_0000);
        wr(9, 32'h1);
        rd(12, d);
        cnt = 0;
        while (!irq && cnt < 2000) begin @(negedge clk); cnt++; end
        den = 0;
        for (int i = 0; i < 56; i++) begin
            do @(negedge clk); while (!pix_ce);
            if (de) den++;
        end
        chk(den == 12, "R5 active pixels vbp2", den, 12);
        // R8 depth modes and R6 polarity (compared each clock by the model)
        for (int m = 0; m < 3; m++) begin
            wr(5, 32'(m << 8) | 32'(m + 1));
            repeat (120) @(negedge clk);
        end
        wr(5, 32'h0000_0003);
        while (!de) @(negedge clk);
        chk((rgb & 24'h0F0F0F) == 0, "R8 4-bit lanes", rgb & 24'h0F0F0F, 0);
        // R7/R2 teardown in reverse order
        wr(7, 32'h4);
        poll(2, 0, "R2 display down");
        repeat (100) @(negedge clk);
        chk(de == 0 && rgb == 0, "R7 data gated after display off", rgb, 0);
        wr(7, 32'h2);
        poll(1, 0, "R2 sync down");
        chk(hsync == 1 && vsync == 1, "R6 inactive level inverted", {hsync, vsync}, 3);
        wr(7, 32'h1);
        poll(0, 0, "R2 pclk down");
        repeat (20) @(negedge clk);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (150000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule